// File: doc/BRIEF.md
# Sticky Line-Event Interrupt Flags

This block collects eight line-interface events into one byte of sticky flags for a telephone line interface controller. A flag is set when its detector reports an event. It stays set until software writes a 0 to that bit position. A per-bit mask and a global enable select which flags may raise the single active-high interrupt output. Software can then read the flags, find the cause, and acknowledge each cause on its own.

The ring flag watches a ring level and can latch on the rising edge only, or on both edges. The frame flag follows a frame-lock level: it is set on every cycle in which lock is absent. The loop-current overload flag is set when a loop-current code reaches its all-ones maximum. The receive-overload event also sets a separate overload status bit. Clearing the overload flag clears that status bit as well.

A small register port with a 2-bit address and a write strobe gives access to the flags, the mask, a control byte and the status byte. Reads are combinational and have no side effects.

Top module: `line_irq_flags`

## Requirements
- R1: After reset, every register reads 0 at every address and `irq` is 0.
- R2: A one-cycle pulse sets its flag at the next clock edge, at these bit positions: `polPulse` bit 0, `tonePulse` bit 1, `dropPulse` bit 3, `supplyPulse` bit 4, `rovPulse` bit 6.
- R3: A set flag holds with no further event. Writing 1 to a flag bit at address 0 leaves that bit unchanged.
- R4: Writing 0 to a bit at address 0 clears only that flag. If an event for that flag arrives in the same cycle as the clearing write, the flag stays set.
- R5: When control bit 1 (address 2) is 0, flag bit 7 is set only on a rising edge of `ringLevel`.
- R6: When control bit 1 is 1, flag bit 7 is set on both the rising edge and the falling edge of `ringLevel`.
- R7: Flag bit 5 is set on every cycle in which `frameLocked` is low. A clearing write has no effect while lock is absent.
- R8: Flag bit 2 is set when `lcsCode` is all ones. It is not set by any lower code.
- R9: Status bit 0 at address 3 is set with the receive-overload event and is cleared when flag bit 6 is cleared by a write. Writes to address 3 are ignored.
- R10: `irq` is registered. It is 1 one cycle after some flag is set while its mask bit (address 1) and the enable bit (control bit 0) are both 1. It returns to 0 one cycle after the last such flag is cleared or after the enable is cleared.
- R11: The mask byte at address 1 and control bits 1:0 at address 2 read back what was written. Reading any address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 flags, 1 mask, 2 control, 3 status |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `addr` (combinational) |
| ringLevel | input | 1 | Ring detector level |
| rovPulse | input | 1 | Receive overload event pulse |
| frameLocked | input | 1 | Isolation link frame lock level |
| supplyPulse | input | 1 | Line-side supply disruption pulse |
| dropPulse | input | 1 | Supply drop-out event pulse |
| lcsCode | input | LCS_W | Loop-current measurement code |
| tonePulse | input | 1 | Tone detect event pulse |
| polPulse | input | 1 | Polarity reversal event pulse |
| irq | output | 1 | Interrupt output, active high |

## Verification
Flags, the status bit and the mask and control registers take a new value at the clock edge where the event or the write is seen. They can be read at `rdData` straight after that edge. `irq` follows one edge later, because it is registered from the flags. The bench drives inputs two nanoseconds after a rising edge and compares against its reference model one nanosecond after each edge. Directed checks step whole cycles and read just after an edge, so each check lands in the exact cycle its result is due.

// File: rtl/line_irq_pkg.sv
package line_irq_pkg;
  localparam int FLAG_CNT = 8;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 2;

  // flag bit positions (decoded by software)
  localparam int BIT_POL    = 0;
  localparam int BIT_TONE   = 1;
  localparam int BIT_LCSO   = 2;
  localparam int BIT_DROP   = 3;
  localparam int BIT_SUPPLY = 4;
  localparam int BIT_FRAME  = 5;
  localparam int BIT_ROV    = 6;
  localparam int BIT_RING   = 7;

  localparam logic [ADDR_W-1:0] ADR_FLAGS = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_MASK  = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_CTRL  = 2'd2;
  localparam logic [ADDR_W-1:0] ADR_STAT  = 2'd3;

  localparam int CTRL_EN   = 0;
  localparam int CTRL_BOTH = 1;

  typedef struct packed {
    logic                wrFlags;
    logic                wrMask;
    logic                wrCtrl;
    logic [DATA_W-1:0]   data;
    logic [FLAG_CNT-1:0] events;
  } strobe_t;
endpackage

// File: rtl/line_irq_ctrl.sv
module line_irq_ctrl
  import line_irq_pkg::*;
#(
  parameter int LCS_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              bothEdges,
  input  logic              ringLevel,
  input  logic              rovPulse,
  input  logic              frameLocked,
  input  logic              supplyPulse,
  input  logic              dropPulse,
  input  logic [LCS_W-1:0]  lcsCode,
  input  logic              tonePulse,
  input  logic              polPulse,
  output strobe_t           stb
);
  localparam logic [LCS_W-1:0] LCS_MAX = {LCS_W{1'b1}};

  logic ringPrev;
  logic ringRise;
  logic ringFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ringPrev <= 1'b0;
    else       ringPrev <= ringLevel;
  end

  assign ringRise = ringLevel & ~ringPrev;
  assign ringFall = ~ringLevel & ringPrev;

  always_comb begin
    stb         = '0;
    stb.data    = wrData;
    stb.wrFlags = wrEn && (addr == ADR_FLAGS);
    stb.wrMask  = wrEn && (addr == ADR_MASK);
    stb.wrCtrl  = wrEn && (addr == ADR_CTRL);
    stb.events[BIT_RING]   = ringRise | (bothEdges & ringFall);
    stb.events[BIT_ROV]    = rovPulse;
    stb.events[BIT_FRAME]  = ~frameLocked;
    stb.events[BIT_SUPPLY] = supplyPulse;
    stb.events[BIT_DROP]   = dropPulse;
    stb.events[BIT_LCSO]   = (lcsCode == LCS_MAX);
    stb.events[BIT_TONE]   = tonePulse;
    stb.events[BIT_POL]    = polPulse;
  end

  // R5: leading-edge mode ignores the falling edge
  assert_ring_lead_only_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!bothEdges && $fell(ringLevel)) |-> !stb.events[BIT_RING]);
  // R6: both-edge mode reacts to the falling edge
  assert_ring_both_R6: assert property (@(posedge clk) disable iff (!rstN)
    (bothEdges && $fell(ringLevel)) |-> stb.events[BIT_RING]);
  // R5: rising edge always produces a ring event
  assert_ring_rise_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ringLevel) |-> stb.events[BIT_RING]);
  // R11: at most one register write strobe per cycle
  assert_one_write_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrFlags, stb.wrMask, stb.wrCtrl}));
endmodule

// File: rtl/line_irq_datapath.sv
module line_irq_datapath
  import line_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] rdData,
  output logic              bothEdges,
  output logic              irq
);
  logic [FLAG_CNT-1:0] flags;
  logic [FLAG_CNT-1:0] mask;
  logic [1:0]          ctrl;
  logic                rovStat;
  logic [FLAG_CNT-1:0] clrVec;
  logic                irqNext;

  assign clrVec = stb.wrFlags ? ~stb.data[FLAG_CNT-1:0] : '0;

  genvar i;
  generate
    for (i = 0; i < FLAG_CNT; i++) begin : g_flag
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)              flags[i] <= 1'b0;
        else if (stb.events[i]) flags[i] <= 1'b1;
        else if (clrVec[i])     flags[i] <= 1'b0;
      end

      // R2: an event latches its flag at the next edge
      assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
        stb.events[i] |=> flags[i]);
      // R3: a set flag holds unless a clearing write arrives
      assert_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
        (flags[i] && !clrVec[i]) |=> flags[i]);
      // R4: a clearing write without a competing event clears
      assert_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
        (clrVec[i] && !stb.events[i]) |=> !flags[i]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 rovStat <= 1'b0;
    else if (stb.events[BIT_ROV]) rovStat <= 1'b1;
    else if (clrVec[BIT_ROV])  rovStat <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           mask <= '0;
    else if (stb.wrMask) mask <= stb.data[FLAG_CNT-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           ctrl <= '0;
    else if (stb.wrCtrl) ctrl <= stb.data[1:0];
  end

  assign bothEdges = ctrl[CTRL_BOTH];
  assign irqNext   = ctrl[CTRL_EN] && |(flags & mask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irq <= 1'b0;
    else       irq <= irqNext;
  end

  always_comb begin
    unique case (addr)
      ADR_FLAGS: rdData = flags;
      ADR_MASK:  rdData = mask;
      ADR_CTRL:  rdData = {{(DATA_W-2){1'b0}}, ctrl};
      default:   rdData = {{(DATA_W-1){1'b0}}, rovStat};
    endcase
  end

  // R9: clearing the overload flag also clears the mirror
  assert_mirror_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flags[BIT_ROV]) |-> !rovStat);
  // R9: the mirror is set together with the overload event
  assert_mirror_set_R9: assert property (@(posedge clk) disable iff (!rstN)
    stb.events[BIT_ROV] |=> rovStat);
  // R10: disabled output stays low
  assert_irq_off_R10: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl[CTRL_EN] |=> !irq);
  // R10: a qualifying flag raises the output one cycle later
  assert_irq_on_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl[CTRL_EN] && (flags & mask) != '0) |=> irq);
endmodule

// File: rtl/line_irq_flags.sv
module line_irq_flags
  import line_irq_pkg::*;
#(
  parameter int LCS_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              ringLevel,
  input  logic              rovPulse,
  input  logic              frameLocked,
  input  logic              supplyPulse,
  input  logic              dropPulse,
  input  logic [LCS_W-1:0]  lcsCode,
  input  logic              tonePulse,
  input  logic              polPulse,
  output logic              irq
);
  strobe_t stb;
  logic    bothEdges;

  line_irq_ctrl #(.LCS_W(LCS_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .bothEdges(bothEdges), .ringLevel(ringLevel), .rovPulse(rovPulse),
    .frameLocked(frameLocked), .supplyPulse(supplyPulse), .dropPulse(dropPulse),
    .lcsCode(lcsCode), .tonePulse(tonePulse), .polPulse(polPulse), .stb(stb)
  );

  line_irq_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .addr(addr), .rdData(rdData),
    .bothEdges(bothEdges), .irq(irq)
  );
endmodule

// File: tb/line_irq_flags_bench.sv
`timescale 1ns/1ps
module line_irq_flags_bench;
  localparam int LCS_W = 6;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             wrEn = 1'b0;
  logic [1:0]       addr = 2'd0;
  logic [7:0]       wrData = 8'd0;
  logic [7:0]       rdData;
  logic             ringLevel = 1'b0;
  logic             rovPulse = 1'b0;
  logic             frameLocked = 1'b1;
  logic             supplyPulse = 1'b0;
  logic             dropPulse = 1'b0;
  logic [LCS_W-1:0] lcsCode = '0;
  logic             tonePulse = 1'b0;
  logic             polPulse = 1'b0;
  logic             irq;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  line_irq_flags #(.LCS_W(LCS_W)) u_line_irq_flags (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .ringLevel(ringLevel), .rovPulse(rovPulse),
    .frameLocked(frameLocked), .supplyPulse(supplyPulse), .dropPulse(dropPulse),
    .lcsCode(lcsCode), .tonePulse(tonePulse), .polPulse(polPulse), .irq(irq)
  );

  // behavioural reference model
  bit [7:0] mFlags, mMask;
  bit [1:0] mCtrl;
  bit       mStat, mIrq, mRingPrev;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mFlags = 0; mMask = 0; mCtrl = 0; mStat = 0; mIrq = 0; mRingPrev = 0;
    end else begin
      bit [7:0] ev;
      bit [7:0] clr;
      ev = 0;
      ev[7] = (ringLevel && !mRingPrev) || (mCtrl[1] && !ringLevel && mRingPrev);
      ev[6] = rovPulse;
      ev[5] = !frameLocked;
      ev[4] = supplyPulse;
      ev[3] = dropPulse;
      ev[2] = (lcsCode == {LCS_W{1'b1}});
      ev[1] = tonePulse;
      ev[0] = polPulse;
      clr = (wrEn && addr == 2'd0) ? ~wrData : 8'h00;
      mIrq = mCtrl[0] && ((mFlags & mMask) != 0);
      for (int b = 0; b < 8; b++) begin
        if (ev[b]) mFlags[b] = 1;
        else if (clr[b]) mFlags[b] = 0;
      end
      if (ev[6]) mStat = 1;
      else if (clr[6]) mStat = 0;
      if (wrEn && addr == 2'd1) mMask = wrData;
      if (wrEn && addr == 2'd2) mCtrl = wrData[1:0];
      mRingPrev = ringLevel;
    end
  end

  function automatic bit [7:0] modelRead(input bit [1:0] a);
    case (a)
      2'd0: return mFlags;
      2'd1: return mMask;
      2'd2: return {6'd0, mCtrl};
      default: return {7'd0, mStat};
    endcase
  endfunction

  // per-cycle comparison, 1 ns after each rising edge
  always @(posedge clk) begin
    #1;
    total++;
    if (irq !== mIrq) begin
      bad++;
      $display("FAIL R10 irq model: actual=%0b expected=%0b", irq, mIrq);
    end
    total++;
    if (rdData !== modelRead(addr)) begin
      bad++;
      $display("FAIL %s rdData model addr=%0d: actual=%02h expected=%02h",
               addr == 2'd0 ? "R3" : addr == 2'd3 ? "R9" : "R11",
               addr, rdData, modelRead(addr));
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] v);
    addr = a;
    #0.5;
    v = rdData;
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    wrEn = 1; addr = a; wrData = d;
    tick();
    wrEn = 0;
  endtask

  task automatic pulse(ref logic sig);
    sig = 1;
    tick();
    sig = 0;
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) tick();
    rstN = 1;
    tick();
    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      peek(a[1:0], v); chk("R1", v, 8'h00);
    end
    chk("R1 irq", {7'd0, irq}, 8'h00);

    // R11: mask/control read back, reads have no effect
    wrReg(2'd1, 8'hA5); peek(2'd1, v); chk("R11", v, 8'hA5);
    peek(2'd1, v); chk("R11 reread", v, 8'hA5);
    wrReg(2'd2, 8'hFE); peek(2'd2, v); chk("R11", v, 8'h02);
    wrReg(2'd2, 8'h00); wrReg(2'd1, 8'h00);

    // R2: pulse events
    pulse(polPulse);    peek(2'd0, v); chk("R2 pol", v, 8'h01);
    pulse(tonePulse);   peek(2'd0, v); chk("R2 tone", v, 8'h03);
    pulse(dropPulse);   peek(2'd0, v); chk("R2 drop", v, 8'h0B);
    pulse(supplyPulse); peek(2'd0, v); chk("R2 supply", v, 8'h1B);
    pulse(rovPulse);    peek(2'd0, v); chk("R2 rov", v, 8'h5B);
    peek(2'd3, v); chk("R9 set", v, 8'h01);

    // R3: sticky and write-1 ignored
    repeat (3) tick();
    peek(2'd0, v); chk("R3 hold", v, 8'h5B);
    wrReg(2'd0, 8'hFF); peek(2'd0, v); chk("R3 write1", v, 8'h5B);

    // R9: status writes ignored
    wrReg(2'd3, 8'h00); peek(2'd3, v); chk("R9 wr ignored", v, 8'h01);

    // R4: single bit clear, set wins
    wrReg(2'd0, 8'hFE); peek(2'd0, v); chk("R4 clear bit0", v, 8'h5A);
    polPulse = 1; wrReg(2'd0, 8'h00); polPulse = 0;
    peek(2'd0, v); chk("R4 set wins", v, 8'h01);
    peek(2'd3, v); chk("R9 cleared", v, 8'h00);
    wrReg(2'd0, 8'h00);

    // R5: leading-edge ring mode
    ringLevel = 1; tick(); peek(2'd0, v); chk("R5 rise", v, 8'h80);
    wrReg(2'd0, 8'h7F); peek(2'd0, v); chk("R5 clear high", v, 8'h00);
    ringLevel = 0; tick(); tick(); peek(2'd0, v); chk("R5 fall ignored", v, 8'h00);

    // R6: both-edge ring mode
    wrReg(2'd2, 8'h02);
    ringLevel = 1; tick(); peek(2'd0, v); chk("R6 rise", v, 8'h80);
    wrReg(2'd0, 8'h00); peek(2'd0, v); chk("R6 cleared", v, 8'h00);
    ringLevel = 0; tick(); peek(2'd0, v); chk("R6 fall", v, 8'h80);
    wrReg(2'd0, 8'h00); wrReg(2'd2, 8'h00);

    // R7: frame lock loss
    frameLocked = 0; tick(); peek(2'd0, v); chk("R7 set", v, 8'h20);
    wrReg(2'd0, 8'h00); peek(2'd0, v); chk("R7 clear blocked", v, 8'h20);
    frameLocked = 1; tick();
    wrReg(2'd0, 8'h00); peek(2'd0, v); chk("R7 cleared", v, 8'h00);

    // R8: loop-current maximum
    lcsCode = {LCS_W{1'b1}} - 1'b1; tick(); tick();
    peek(2'd0, v); chk("R8 below max", v, 8'h00);
    lcsCode = {LCS_W{1'b1}}; tick(); lcsCode = '0;
    peek(2'd0, v); chk("R8 max", v, 8'h04);
    wrReg(2'd0, 8'h00);

    // R10: interrupt timing
    wrReg(2'd1, 8'h01); wrReg(2'd2, 8'h01);
    pulse(polPulse);
    chk("R10 not yet", {7'd0, irq}, 8'h00);
    tick(); chk("R10 rise", {7'd0, irq}, 8'h01);
    pulse(tonePulse); tick();
    chk("R10 unmasked no effect", {7'd0, irq}, 8'h01);
    wrReg(2'd0, 8'hFE);
    chk("R10 one late", {7'd0, irq}, 8'h01);
    tick(); chk("R10 fall", {7'd0, irq}, 8'h00);
    wrReg(2'd1, 8'h02); tick();
    chk("R10 remask", {7'd0, irq}, 8'h01);
    wrReg(2'd2, 8'h00); tick();
    chk("R10 disabled", {7'd0, irq}, 8'h00);

    repeat (4) tick();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule